// File: doc/BRIEF.md
# Bidirectional Parity Bus Transceiver

This block joins two 8-bit data buses, called side A and side B. One direction control picks the way data moves. When it is high, side A drives side B (transmit). When it is low, side B drives side A (receive). An active-low output enable can put every driver of the block into the idle state at once. Each bus side is modelled as an input vector, an output vector and a drive-enable bit. A chip-level pad ring or a testbench resolves these into tri-state nets.

A single parity line changes role with the direction. In transmit, the block computes a parity bit over side A and drives it onto the line. In receive, the block samples the line and checks it against side B. It reports a mismatch on an active-low error output. A sense select chooses even or odd parity. The block is purely combinational, so every output follows its inputs within the same cycle.

Top module: `pbt_transceiver`

## Requirements
- R1: With dir_tx=1 and oe_n=0, b_oe is 1, a_oe is 0 and b_out equals a_in bit for bit, without inversion.
- R2: With dir_tx=0 and oe_n=0, a_oe is 1, b_oe is 0 and a_out equals b_in bit for bit, without inversion.
- R3: With oe_n=1, a_oe, b_oe and par_oe are all 0, and a_out, b_out and par_out are all 0.
- R4: a_oe and b_oe are never 1 at the same time.
- R5: In transmit with odd_sel=0 (even sense) and outputs enabled, par_out is 1 exactly when a_in holds an odd number of ones.
- R6: In transmit with odd_sel=1 (odd sense) and outputs enabled, par_out is the complement of the even-sense value.
- R7: par_oe is 1 only in transmit with oe_n=0. In receive, par_out is 0.
- R8: In receive with odd_sel=0, err_n is 0 exactly when the nine bits {b_in, par_in} hold an odd number of ones.
- R9: In receive with odd_sel=1, err_n is 0 exactly when the nine bits {b_in, par_in} hold an even number of ones.
- R10: In transmit, err_n is 1 whatever the data, sense or enable.
- R11: In receive, err_n follows R8 and R9 also while oe_n=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_tx | input | 1 | 1: side A drives side B; 0: side B drives side A |
| oe_n | input | 1 | Active-low enable for all drivers |
| odd_sel | input | 1 | Parity sense: 0 even, 1 odd |
| a_in | input | 8 | Value sampled from side A |
| a_out | output | 8 | Value driven onto side A |
| a_oe | output | 1 | Side A driver enable |
| b_in | input | 8 | Value sampled from side B |
| b_out | output | 8 | Value driven onto side B |
| b_oe | output | 1 | Side B driver enable |
| par_in | input | 1 | Value sampled from the parity line |
| par_out | output | 1 | Generated parity driven onto the parity line |
| par_oe | output | 1 | Parity line driver enable |
| err_n | output | 1 | Active-low parity mismatch flag, valid in receive |

## Verification
The hardest case to reach is the receive check while the block drives nothing. In that state no output moves except err_n, so a fault in the check path under oe_n=1 is hidden by any test that looks only at the data ports. The stimulus sweeps every side-B value with both parity-line levels and both senses, and it repeats that sweep with the enable off. Every one of the 512 nine-bit totals therefore reaches err_n under both enable states. Directed vectors add the single-bit and all-ones patterns, where a parity tree with a dropped or doubled leaf shows up first.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
  typedef enum logic {
    PBT_RECEIVE  = 1'b0,
    PBT_TRANSMIT = 1'b1
  } pbt_dir_e;

  typedef struct packed {
    logic side_a;
    logic side_b;
    logic parity;
  } pbt_drive_t;
endpackage

// File: rtl/pbt_xor_tree.sv
module pbt_xor_tree #(
  parameter int N = 8
) (
  input  logic [N-1:0] bits_i,
  output logic         odd_o
);
  localparam int LEVELS = (N > 1) ? $clog2(N) : 0;
  localparam int PAD    = 1 << LEVELS;
  localparam int NODES  = 2 * PAD - 1;

  logic [NODES-1:0] node;

  always_comb begin
    node = '0;
    for (int i = 0; i < N; i++) begin
      node[PAD-1+i] = bits_i[i];
    end
    for (int k = PAD - 2; k >= 0; k--) begin
      node[k] = node[2*k+1] ^ node[2*k+2];
    end
  end

  assign odd_o = node[0];
endmodule

// File: rtl/pbt_route.sv
module pbt_route
  import pbt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  pbt_dir_e         dir_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] b_o,
  output pbt_drive_t       drv_o
);
  always_comb begin
    drv_o        = '0;
    drv_o.side_b = en_i && (dir_i == PBT_TRANSMIT);
    drv_o.parity = en_i && (dir_i == PBT_TRANSMIT);
    drv_o.side_a = en_i && (dir_i == PBT_RECEIVE);
  end

  assign b_o = drv_o.side_b ? a_i : '0;
  assign a_o = drv_o.side_a ? b_i : '0;
endmodule

// File: rtl/pbt_parity_unit.sv
module pbt_parity_unit
  import pbt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  pbt_dir_e         dir_i,
  input  logic             drive_par_i,
  input  logic             odd_sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             par_i,
  output logic             par_o,
  output logic             err_n_o
);
  localparam int CHK_W = WIDTH + 1;

  logic gen_odd;
  logic chk_odd;

  pbt_xor_tree #(.N(WIDTH)) u_gen_tree (
    .bits_i(a_i),
    .odd_o (gen_odd)
  );

  pbt_xor_tree #(.N(CHK_W)) u_chk_tree (
    .bits_i({b_i, par_i}),
    .odd_o (chk_odd)
  );

  // even sense: parity bit makes the total even; odd sense inverts it
  assign par_o = drive_par_i ? (gen_odd ^ odd_sel_i) : 1'b0;

  // mismatch when the nine-bit total disagrees with the chosen sense
  assign err_n_o = (dir_i == PBT_TRANSMIT) ? 1'b1 : ~(chk_odd ^ odd_sel_i);
endmodule

// File: rtl/pbt_transceiver.sv
module pbt_transceiver
  import pbt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dir_tx,
  input  logic             oe_n,
  input  logic             odd_sel,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             par_in,
  output logic             par_out,
  output logic             par_oe,
  output logic             err_n
);
  pbt_dir_e   dir;
  pbt_drive_t drv;

  assign dir = dir_tx ? PBT_TRANSMIT : PBT_RECEIVE;

  pbt_route #(.WIDTH(WIDTH)) u_route (
    .dir_i(dir),
    .en_i (~oe_n),
    .a_i  (a_in),
    .b_i  (b_in),
    .a_o  (a_out),
    .b_o  (b_out),
    .drv_o(drv)
  );

  pbt_parity_unit #(.WIDTH(WIDTH)) u_parity (
    .dir_i      (dir),
    .drive_par_i(drv.parity),
    .odd_sel_i  (odd_sel),
    .a_i        (a_in),
    .b_i        (b_in),
    .par_i      (par_in),
    .par_o      (par_out),
    .err_n_o    (err_n)
  );

  assign a_oe   = drv.side_a;
  assign b_oe   = drv.side_b;
  assign par_oe = drv.parity;
endmodule

// File: rtl/pbt_transceiver_chk.sv
module pbt_transceiver_chk #(
  parameter int WIDTH = 8
) (
  input logic             dir_tx,
  input logic             oe_n,
  input logic             odd_sel,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             par_in,
  input logic             par_out,
  input logic             par_oe,
  input logic             err_n
);
  always_comb begin
    // R4
    one_driver_chk: assert (!(a_oe && b_oe))
      else $error("both sides driven");
    // R3
    idle_when_off_chk: assert (!oe_n || (!a_oe && !b_oe && !par_oe))
      else $error("driver active while disabled");
    // R1
    a_to_b_copy_chk: assert (!b_oe || (b_out == a_in))
      else $error("side B not a copy of side A");
    // R2
    b_to_a_copy_chk: assert (!a_oe || (a_out == b_in))
      else $error("side A not a copy of side B");
    // R7
    par_drive_mode_chk: assert (!par_oe || (dir_tx && !oe_n))
      else $error("parity driven outside transmit");
    // R10
    err_idle_in_tx_chk: assert (!dir_tx || err_n)
      else $error("error flagged in transmit");
    // R5
    tx_parity_total_chk: assert (!par_oe || ((^{a_in, par_out}) == odd_sel))
      else $error("generated parity wrong");
    // R8
    rx_check_chk: assert (dir_tx || (err_n == ((^{b_in, par_in}) == odd_sel)))
      else $error("receive check wrong");
  end
endmodule

bind pbt_transceiver pbt_transceiver_chk #(.WIDTH(WIDTH)) i_pbt_transceiver_chk (
  .dir_tx (dir_tx),
  .oe_n   (oe_n),
  .odd_sel(odd_sel),
  .a_in   (a_in),
  .a_out  (a_out),
  .a_oe   (a_oe),
  .b_in   (b_in),
  .b_out  (b_out),
  .b_oe   (b_oe),
  .par_in (par_in),
  .par_out(par_out),
  .par_oe (par_oe),
  .err_n  (err_n)
);

// File: tb/test_pbt_transceiver.sv
module test_pbt_transceiver;
  localparam int W = 8;
  localparam int NV = 10;
  // {dir, oe_n, odd, par_in, a[8], b[8], a_oe, b_oe, par_oe, par_out, err_n}
  localparam logic [24:0] VEC [NV] = '{
    {4'b1000, 8'h01, 8'h00, 5'b01111},   // R5 single one, even
    {4'b1000, 8'h03, 8'h00, 5'b01101},   // R5 two ones, even
    {4'b1010, 8'h03, 8'h00, 5'b01111},   // R6 odd sense
    {4'b1010, 8'hFF, 8'h00, 5'b01111},   // R6 all ones, odd
    {4'b0001, 8'h00, 8'h01, 5'b10001},   // R8 total even: ok
    {4'b0001, 8'h00, 8'h00, 5'b10000},   // R8 total odd: error
    {4'b0010, 8'h00, 8'h00, 5'b10000},   // R9 total even: error
    {4'b0011, 8'h00, 8'h00, 5'b10001},   // R9 total odd: ok
    {4'b0100, 8'h00, 8'h01, 5'b00000},   // R11 disabled receive error
    {4'b1100, 8'h01, 8'h00, 5'b00001}    // R3 disabled transmit
  };

  logic clk;
  logic rst_n;
  logic dir_tx, oe_n, odd_sel, par_in;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, par_out, par_oe, err_n;
  int n_chk, n_bad, cyc;
  logic done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  pbt_transceiver #(.WIDTH(W)) i_pbt_transceiver (
    .dir_tx(dir_tx), .oe_n(oe_n), .odd_sel(odd_sel),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .err_n(err_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic apply(input logic d, input logic o, input logic s, input logic p,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    dir_tx = d; oe_n = o; odd_sel = s; par_in = p; a_in = a; b_in = b;
    @(negedge clk);
  endtask

  task automatic model_check();
    logic en, ea, eb, ep, epo, ee;
    int tot;
    en  = !oe_n;
    ea  = en && !dir_tx;
    eb  = en && dir_tx;
    ep  = en && dir_tx;
    epo = ep ? (((ones(a_in) % 2) == 1) ^ odd_sel) : 1'b0;
    tot = ones(b_in) + int'(par_in);
    ee  = dir_tx ? 1'b1 : !(((tot % 2) == 1) ^ odd_sel);
    chk("R2 a_oe", a_oe, ea);
    chk("R1 b_oe", b_oe, eb);
    chk("R4 exclusive", a_oe & b_oe, 0);
    chk("R1 b_out", b_out, eb ? a_in : '0);
    chk("R2 a_out", a_out, ea ? b_in : '0);
    chk("R7 par_oe", par_oe, ep);
    chk(odd_sel ? "R6 par_out" : "R5 par_out", par_out, epo);
    chk(dir_tx ? "R10 err_n" : (oe_n ? "R11 err_n" : (odd_sel ? "R9 err_n" : "R8 err_n")), err_n, ee);
  endtask

  initial begin
    cyc = 0;
    done = 1'b0;
    @(posedge clk);
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    dir_tx = 1'b0; oe_n = 1'b1; odd_sel = 1'b0; par_in = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state: disabled, nothing driven
    chk("R3 idle oe", {a_oe, b_oe, par_oe}, 0);
    chk("R3 idle data", {a_out, b_out, par_out}, 0);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][24], VEC[v][23], VEC[v][22], VEC[v][21], VEC[v][20:13], VEC[v][12:5]);
      chk("R1/R2 table a_oe", a_oe, VEC[v][4]);
      chk("R1 table b_oe", b_oe, VEC[v][3]);
      chk("R7 table par_oe", par_oe, VEC[v][2]);
      chk("R5 table par_out", par_out, VEC[v][1]);
      chk("R8 table err_n", err_n, VEC[v][0]);
      model_check();
    end

    // exhaustive sweep
    for (int m = 0; m < 16; m++) begin
      for (int d = 0; d < 256; d++) begin
        apply(m[3], m[2], m[1], m[0], W'(d), W'(d ^ 8'h5A));
        model_check();
      end
    end

    // corner: disabled transmit with odd sense never drives parity
    apply(1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF);
    chk("R3 off par_out", par_out, 0);
    chk("R10 off err_n", err_n, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule